// File: doc/BRIEF.md
# External Interrupt Sense and Latch

This block sits between eight external interrupt pins and a parent interrupt controller. Every pin first passes through a two-stage synchroniser. A per-pin two-bit mode field then chooses what counts as an interrupt: a low level, a falling edge, a rising edge, or either edge. Each detected condition sets a status bit. That bit drives an active-high level request to the parent and stays set until software clears it.

Software reaches the block over a plain 32-bit register bus with single-cycle write and read strobes. Two registers are mapped. The status register sits at offset 0x10 and the mode register at offset 0x14. Read data is combinational, so a read issued in the cycle right after a clear already returns the cleared value.

Clearing only works in the edge modes. In level-low mode the status bit simply follows the inverted synchronised pin. Prioritisation, masking and vectoring are left to the parent controller.

Top module: `ext_irq_sense`

## Requirements
- R1: While the synchronous reset is high, the status register (0x10) and the mode register (0x14) read as zero and every request output is low.
- R2: The mode register at 0x14 holds two bits per pin, at bits [2n+1:2n]. Its encoding is 0 = level low, 1 = falling edge, 2 = rising edge, 3 = both edges. Bits above bit 15 read as zero.
- R3: In level-low mode, status bit n equals the inverse of pin n. A pin change shows up in the status after the third rising clock edge and not after the second.
- R4: In rising-edge mode, status bit n sets on a 0-to-1 transition of pin n and not on a 1-to-0 transition.
- R5: In falling-edge mode, status bit n sets on a 1-to-0 transition of pin n and not on a 0-to-1 transition.
- R6: In both-edges mode, status bit n sets on either transition of pin n.
- R7: In an edge mode, writing 0x10 with bit n equal to 0 clears status bit n, and a read in the very next cycle returns the cleared value. Writing bit n equal to 1 leaves the bit unchanged and never sets it.
- R8: In level-low mode, writes to the status register have no effect on status bit n.
- R9: If a detected edge and a clear write for the same pin land on the same clock edge, the status bit stays set.
- R10: Request output n is high exactly when status bit n (bit n of a read at 0x10) is set.
- R11: In an edge mode, a set status bit stays set after the pin returns to its earlier level, until software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| pin_in | input | 8 | Asynchronous external interrupt pins |
| irq_req | output | 8 | Level requests toward the parent controller |

## Verification
The bench sweeps every pin through each of the three edge modes, in both transition directions. A design with a swapped mode decode would latch the wrong edge, or latch nothing. The bench counts the synchroniser latency cycle by cycle, so an extra or missing flop fails the check. It issues a clear in exactly the cycle an edge is detected; a design that lets the clear win would drop that interrupt. It also confirms that clears do nothing in level-low mode and that writing ones never sets a bit. A design that decoded the written value the wrong way round would either set spurious interrupts or leave level requests clearable.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int NUM_PINS_DEF = 8;
    localparam int ADDR_W_DEF   = 8;
    localparam int DATA_W_DEF   = 32;
    localparam int STAT_OFS     = 'h10;
    localparam int MODE_OFS     = 'h14;

    typedef enum logic [1:0] {
        MODE_LVL_LO = 2'd0,
        MODE_FALL   = 2'd1,
        MODE_RISE   = 2'd2,
        MODE_BOTH   = 2'd3
    } pin_mode_e;

    typedef struct packed {
        logic wr_stat;
        logic wr_mode;
        logic rd_stat;
        logic rd_mode;
    } bus_dec_t;

    // Edge qualification for one pin, given previous and current samples.
    function automatic logic edge_hit(pin_mode_e m, logic prv, logic cur);
        case (m)
            MODE_FALL: return prv & ~cur;
            MODE_RISE: return ~prv & cur;
            MODE_BOTH: return prv ^ cur;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;
endmodule

// File: rtl/ext_irq_pin_cell.sv
module ext_irq_pin_cell
    import ext_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_mode_e mode,
    input  logic      smp,
    input  logic      clr_req,
    output logic      hit_o,
    output logic      stat_o
);
    logic prev_q;
    logic stat_q;

    assign hit_o = edge_hit(mode, prev_q, smp);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            prev_q <= smp;
            if (mode == MODE_LVL_LO)
                stat_q <= ~smp;       // level mode: follows pin, not clearable
            else if (hit_o)
                stat_q <= 1'b1;       // a fresh edge beats a clear
            else if (clr_req)
                stat_q <= 1'b0;
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter int NUM_PINS = NUM_PINS_DEF,
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int DATA_W   = DATA_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic [NUM_PINS-1:0]   stat_in,
    output logic [2*NUM_PINS-1:0] mode_q,
    output logic [NUM_PINS-1:0]   clr_req,
    output logic [DATA_W-1:0]     bus_rdata
);
    localparam int MODE_W = 2 * NUM_PINS;

    bus_dec_t dec;

    always_comb begin
        dec.wr_stat = bus_wr && (bus_addr == ADDR_W'(STAT_OFS));
        dec.wr_mode = bus_wr && (bus_addr == ADDR_W'(MODE_OFS));
        dec.rd_stat = bus_rd && (bus_addr == ADDR_W'(STAT_OFS));
        dec.rd_mode = bus_rd && (bus_addr == ADDR_W'(MODE_OFS));
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else if (dec.wr_mode)
            mode_q <= bus_wdata[MODE_W-1:0];
    end

    // A zero written into a status bit requests its clear.
    assign clr_req = dec.wr_stat ? ~bus_wdata[NUM_PINS-1:0] : '0;

    always_comb begin
        bus_rdata = '0;
        if (dec.rd_stat)
            bus_rdata[NUM_PINS-1:0] = stat_in;
        if (dec.rd_mode)
            bus_rdata[MODE_W-1:0] = mode_q;
    end

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:MODE_W];
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import ext_irq_pkg::*;
#(
    parameter int NUM_PINS = NUM_PINS_DEF,
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int DATA_W   = DATA_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] irq_req
);
    logic [NUM_PINS-1:0]   pin_s;
    logic [2*NUM_PINS-1:0] mode_q;
    logic [NUM_PINS-1:0]   clr_req;
    logic [NUM_PINS-1:0]   hit;
    logic [NUM_PINS-1:0]   stat_q;

    ext_irq_sync #(.W(NUM_PINS)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_in),
        .d_sync  (pin_s)
    );

    ext_irq_regs #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .stat_in   (stat_q),
        .mode_q    (mode_q),
        .clr_req   (clr_req),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        ext_irq_pin_cell cell_i (
            .clk     (clk),
            .rst     (rst),
            .mode    (pin_mode_e'(mode_q[2*g +: 2])),
            .smp     (pin_s[g]),
            .clr_req (clr_req[g]),
            .hit_o   (hit[g]),
            .stat_o  (stat_q[g])
        );
    end

    assign irq_req = stat_q;
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk
    import ext_irq_pkg::*;
#(
    parameter int NUM_PINS = NUM_PINS_DEF,
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int DATA_W   = DATA_W_DEF
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic [NUM_PINS-1:0]   pin_s,
    input logic [2*NUM_PINS-1:0] mode_q,
    input logic [NUM_PINS-1:0]   hit,
    input logic [NUM_PINS-1:0]   stat_q,
    input logic [NUM_PINS-1:0]   irq_req
);
    // R1
    reset_clears_req_chk: assert property (@(posedge clk)
        rst |=> (irq_req == '0));

    // R10
    read_matches_req_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(STAT_OFS))
            |-> (bus_rdata == DATA_W'(irq_req)));

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
        // R3 R8
        level_follows_pin_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(mode_q[2*n +: 2]) == 2'd0)
                |-> (stat_q[n] == ~$past(pin_s[n])));

        // R9
        edge_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
            (hit[n] && mode_q[2*n +: 2] != 2'd0) |=> stat_q[n]);

        // R7
        clear_takes_effect_chk: assert property (@(posedge clk) disable iff (rst)
            (!hit[n] && mode_q[2*n +: 2] != 2'd0 && bus_wr
             && bus_addr == ADDR_W'(STAT_OFS) && !bus_wdata[n])
                |=> !stat_q[n]);

        // R4
        no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
            (!hit[n] && !stat_q[n] && mode_q[2*n +: 2] != 2'd0) |=> !stat_q[n]);
    end
endmodule

bind ext_irq_sense ext_irq_sense_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_s     (pin_s),
    .mode_q    (mode_q),
    .hit       (hit),
    .stat_q    (stat_q),
    .irq_req   (irq_req)
);

// File: tb/ext_irq_sense_tb.sv
`timescale 1ns/1ps
module ext_irq_sense_tb_top;
    localparam logic [7:0] A_STAT = 8'h10;
    localparam logic [7:0] A_MODE = 8'h14;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = 8'hFF;
    logic [7:0]  irq_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ext_irq_sense dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .irq_req   (irq_req)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Called at a negedge; the write lands on the following posedge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #0.5;
        d = bus_rdata;
        bus_rd   = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_stat(input string tag, input logic [7:0] exp);
        logic [31:0] v;
        rd(A_STAT, v);
        chk(tag, v, {24'b0, exp});
        chk({tag, " (R10 request)"}, {24'b0, irq_req}, {24'b0, exp});
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  pats [4] = '{8'h00, 8'hA5, 8'h5A, 8'h0F};

        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1
        rd(A_STAT, v); chk("R1 status in reset", v, 32'h0);
        rd(A_MODE, v); chk("R1 mode in reset", v, 32'h0);
        chk("R1 request in reset", {24'b0, irq_req}, 32'h0);
        rst = 1'b0;
        settle();
        chk_stat("R3 pins high", 8'h00);

        // R3 level-low patterns
        foreach (pats[i]) begin
            pin_in = pats[i];
            settle();
            chk_stat("R3 level pattern", ~pats[i]);
        end

        // R3 latency: visible after third edge, not second
        pin_in = 8'hFF; settle();
        pin_in = 8'h00;
        @(negedge clk); @(negedge clk);
        chk_stat("R3 latency two edges", 8'h00);
        @(negedge clk);
        chk_stat("R3 latency three edges", 8'hFF);

        // R8 clear ignored in level mode
        wr(A_STAT, 32'h0);
        chk_stat("R8 level clear ignored", 8'hFF);

        // R2 mode register readback
        wr(A_MODE, 32'hDEAD_1B4E);
        rd(A_MODE, v); chk("R2 mode readback", v, 32'h0000_1B4E);
        wr(A_MODE, 32'h0);
        pin_in = 8'hFF; settle();

        // R4 R5 R6 R7 sweep over pins and edge modes
        for (int n = 0; n < 8; n++) begin
            for (int m = 1; m < 4; m++) begin
                logic [7:0] bit_n;
                logic [7:0] exp_f;
                logic [7:0] exp_r;
                bit_n = 8'(1 << n);
                exp_f = (m == 1 || m == 3) ? bit_n : 8'h00;
                exp_r = (m == 2 || m == 3) ? bit_n : 8'h00;
                wr(A_MODE, 32'(m) << (2 * n));
                wr(A_STAT, 32'h0);
                pin_in[n] = 1'b0; settle();
                case (m)
                    1: chk_stat("R5 falling mode, fall", exp_f);
                    2: chk_stat("R4 rising mode, fall", exp_f);
                    default: chk_stat("R6 both mode, fall", exp_f);
                endcase
                wr(A_STAT, 32'h0);
                chk_stat("R7 clear visible next read", 8'h00);
                pin_in[n] = 1'b1; settle();
                case (m)
                    1: chk_stat("R5 falling mode, rise", exp_r);
                    2: chk_stat("R4 rising mode, rise", exp_r);
                    default: chk_stat("R6 both mode, rise", exp_r);
                endcase
                wr(A_STAT, 32'h0);
                wr(A_MODE, 32'h0);
            end
        end

        // R11 hold after pin returns
        wr(A_MODE, 32'h2 << 6);
        pin_in[3] = 1'b0; settle();
        wr(A_STAT, 32'h0);
        pin_in[3] = 1'b1; settle();
        pin_in[3] = 1'b0; settle();
        chk_stat("R11 held after pin returns", 8'h08);

        // R7 writing ones does nothing
        wr(A_STAT, 32'hFF);
        chk_stat("R7 write one keeps bit", 8'h08);
        wr(A_STAT, 32'hFFFF_FFF7);
        chk_stat("R7 selective clear", 8'h00);
        wr(A_STAT, 32'hFF);
        chk_stat("R7 write one never sets", 8'h00);

        // R9 edge and clear on same clock edge
        pin_in[3] = 1'b1;
        @(negedge clk); @(negedge clk);
        wr(A_STAT, 32'h0);
        chk_stat("R9 edge beats clear", 8'h08);
        wr(A_STAT, 32'h0);
        chk_stat("R9 later clear works", 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule